// File: doc/BRIEF.md
# Hot-plug detect pulse classifier

This block watches the hot-plug-detect level driven by a display sink and turns it into a clean connection flag and three kinds of single-cycle event. A high level means a sink is attached. When the line drops while a sink is attached, the block measures how long it stays low. A short dip is treated as noise and ignored. A dip of medium length is reported as an interrupt request from the sink once the line comes back high. A long low is reported as a disconnect as soon as it has lasted long enough, without waiting for the line to rise.

The raw level first passes through a two-flop synchronizer. A four-state machine then works on the synchronized level: `ST_DETACHED` (line low, no sink), `ST_ARMING` (line high, counting a qualifying high run), `ST_ATTACHED` (sink present, line high) and `ST_LOW_MEASURE` (sink present, line low, measuring the dip). The transitions are: DETACHED→ARMING on a high sample; ARMING→ATTACHED when the high run reaches `GLITCH_CYC` samples (plug event); ARMING→DETACHED on a low sample; ATTACHED→LOW_MEASURE on a low sample; LOW_MEASURE→ATTACHED on a high sample (interrupt event if the dip lasted at least `GLITCH_CYC` samples); LOW_MEASURE→DETACHED when the dip reaches `UNPLUG_CYC` samples (unplug event). Both thresholds are parameters in clock cycles. The defaults, 25000 and 200000, give 0.25 ms and 2 ms at 100 MHz. `GLITCH_CYC` must be at least 2 and smaller than `UNPLUG_CYC`.

Top module: `hpd_pulse_classifier`

## Requirements
- R1: After a synchronous reset (`rst` high), `connected` is 0 and none of `irq_pulse`, `plug_pulse` or `unplug_pulse` is set.
- R2: While disconnected, `GLITCH_CYC` consecutive high samples set `connected` and raise `plug_pulse` for one cycle, in the same cycle as `connected` rises.
- R3: While disconnected, a high run shorter than `GLITCH_CYC` samples produces no plug event, and `connected` stays 0.
- R4: While connected, a low run shorter than `GLITCH_CYC` samples produces no event, and `connected` stays 1.
- R5: While connected, a low run of `GLITCH_CYC` to `UNPLUG_CYC`-1 samples produces exactly one `irq_pulse`, in the cycle after the first high sample that ends it. `connected` stays 1 throughout.
- R6: While connected, the `UNPLUG_CYC`-th consecutive low sample clears `connected` and raises `unplug_pulse` for one cycle while the line is still low.
- R7: A low run longer than `UNPLUG_CYC` produces no further event, and its end raises no `irq_pulse`. The run-length counter never exceeds `UNPLUG_CYC`.
- R8: Each event output is high for one cycle only. At most one of the three event outputs is high in any cycle.
- R9: The level sampled by the state machine at a clock edge is the one `hpd_raw` held two edges earlier. Results are registered at that edge, so a plug event appears `GLITCH_CYC`+2 edges after the first edge at which `hpd_raw` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hpd_raw | input | 1 | Asynchronous hot-plug-detect level from the sink |
| connected | output | 1 | Sink-attached flag |
| irq_pulse | output | 1 | One-cycle pulse: interrupt request from the sink |
| plug_pulse | output | 1 | One-cycle pulse: sink attached |
| unplug_pulse | output | 1 | One-cycle pulse: sink detached |

## Verification
The classifier is driven with low excursions of exactly `GLITCH_CYC`-1, `GLITCH_CYC`, `UNPLUG_CYC`-1 and `UNPLUG_CYC` samples. These pin down each boundary between glitch, interrupt and unplug. A very long low then shows that the counter saturates and that nothing fires when the line rises again. High runs just short of and exactly at the qualifying length separate an ignored attach glitch from a real plug, and a directed edge count confirms the two-stage synchronizer latency. Random runs of alternating level, drawn from buckets around both thresholds, are checked cycle by cycle against a bench model of the requirements. This covers dips that arrive while the block is still arming and a reconnect that follows an unplug.

// File: rtl/hpdc_pkg.sv
package hpdc_pkg;

    typedef enum logic [1:0] {
        ST_DETACHED    = 2'd0,
        ST_ARMING      = 2'd1,
        ST_ATTACHED    = 2'd2,
        ST_LOW_MEASURE = 2'd3
    } hpd_state_t;

endpackage

// File: rtl/hpdc_sync.sv
module hpdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/hpdc_run_timer.sv
module hpdc_run_timer #(
    parameter int GLITCH_CYC = 25000,
    parameter int UNPLUG_CYC = 200000,
    parameter int CNT_W      = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_one,
    input  logic             advance,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             arm_done,
    output logic             unplug_due,
    output logic             long_enough
);

    localparam logic [CNT_W-1:0] ARM_LAST    = CNT_W'(GLITCH_CYC - 1);
    localparam logic [CNT_W-1:0] UNPLUG_LAST = CNT_W'(UNPLUG_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_MIN    = CNT_W'(GLITCH_CYC);
    localparam logic [CNT_W-1:0] SAT_VALUE   = CNT_W'(UNPLUG_CYC);

    // Counts samples of the current run; the first sample loads one.
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_one) begin
            count <= CNT_W'(1);
        end else if (clear) begin
            count <= '0;
        end else if (advance && (count < SAT_VALUE)) begin
            count <= count + CNT_W'(1);
        end
    end

    assign arm_done    = (count == ARM_LAST);
    assign unplug_due  = (count == UNPLUG_LAST);
    assign long_enough = (count >= LONG_MIN);

endmodule

// File: rtl/hpdc_fsm.sv
module hpdc_fsm
    import hpdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  logic       arm_done,
    input  logic       unplug_due,
    input  logic       long_enough,
    output logic       load_one,
    output logic       advance,
    output logic       clear,
    output hpd_state_t state,
    output logic       connected,
    output logic       irq_pulse,
    output logic       plug_pulse,
    output logic       unplug_pulse
);

    hpd_state_t state_nxt;
    logic       irq_nxt;
    logic       plug_nxt;
    logic       unplug_nxt;
    logic       conn_nxt;

    always_comb begin
        state_nxt  = state;
        load_one   = 1'b0;
        advance    = 1'b0;
        clear      = 1'b0;
        irq_nxt    = 1'b0;
        plug_nxt   = 1'b0;
        unplug_nxt = 1'b0;
        unique case (state)
            ST_DETACHED: begin
                if (lvl) begin
                    state_nxt = ST_ARMING;
                    load_one  = 1'b1;
                end
            end
            ST_ARMING: begin
                if (!lvl) begin
                    state_nxt = ST_DETACHED;
                    clear     = 1'b1;
                end else if (arm_done) begin
                    state_nxt = ST_ATTACHED;
                    plug_nxt  = 1'b1;
                    clear     = 1'b1;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_ATTACHED: begin
                if (!lvl) begin
                    state_nxt = ST_LOW_MEASURE;
                    load_one  = 1'b1;
                end
            end
            ST_LOW_MEASURE: begin
                if (lvl) begin
                    state_nxt = ST_ATTACHED;
                    irq_nxt   = long_enough;
                    clear     = 1'b1;
                end else if (unplug_due) begin
                    state_nxt  = ST_DETACHED;
                    unplug_nxt = 1'b1;
                    clear      = 1'b1;
                end else begin
                    advance = 1'b1;
                end
            end
            default: begin
                state_nxt = ST_DETACHED;
                clear     = 1'b1;
            end
        endcase
        conn_nxt = (state_nxt == ST_ATTACHED) || (state_nxt == ST_LOW_MEASURE);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_DETACHED;
        end else begin
            state <= state_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            connected    <= 1'b0;
            irq_pulse    <= 1'b0;
            plug_pulse   <= 1'b0;
            unplug_pulse <= 1'b0;
        end else begin
            connected    <= conn_nxt;
            irq_pulse    <= irq_nxt;
            plug_pulse   <= plug_nxt;
            unplug_pulse <= unplug_nxt;
        end
    end

endmodule

// File: rtl/hpd_pulse_classifier.sv
module hpd_pulse_classifier
    import hpdc_pkg::*;
#(
    parameter int GLITCH_CYC  = 25000,
    parameter int UNPLUG_CYC  = 200000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hpd_raw,
    output logic connected,
    output logic irq_pulse,
    output logic plug_pulse,
    output logic unplug_pulse
);

    localparam int CNT_W = $clog2(UNPLUG_CYC + 1);

    logic             hpd_lvl;
    logic             load_one;
    logic             advance;
    logic             clear;
    logic [CNT_W-1:0] run_count;
    logic             arm_done;
    logic             unplug_due;
    logic             long_enough;
    hpd_state_t       state;

    hpdc_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (hpd_raw),
        .dout(hpd_lvl)
    );

    hpdc_run_timer #(
        .GLITCH_CYC(GLITCH_CYC),
        .UNPLUG_CYC(UNPLUG_CYC),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_one   (load_one),
        .advance    (advance),
        .clear      (clear),
        .count      (run_count),
        .arm_done   (arm_done),
        .unplug_due (unplug_due),
        .long_enough(long_enough)
    );

    hpdc_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .lvl         (hpd_lvl),
        .arm_done    (arm_done),
        .unplug_due  (unplug_due),
        .long_enough (long_enough),
        .load_one    (load_one),
        .advance     (advance),
        .clear       (clear),
        .state       (state),
        .connected   (connected),
        .irq_pulse   (irq_pulse),
        .plug_pulse  (plug_pulse),
        .unplug_pulse(unplug_pulse)
    );

endmodule

// File: rtl/hpdc_checker.sv
module hpdc_checker #(
    parameter int UNPLUG_CYC = 200000,
    parameter int CNT_W      = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             connected,
    input logic             irq_pulse,
    input logic             plug_pulse,
    input logic             unplug_pulse,
    input logic [CNT_W-1:0] count
);

    logic any_event;
    assign any_event = irq_pulse | plug_pulse | unplug_pulse;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!connected && !any_event));

    assert_rise_has_plug_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(connected) |-> plug_pulse);

    assert_plug_sets_conn_R2: assert property (@(posedge clk) disable iff (rst)
        plug_pulse |-> connected);

    assert_irq_while_conn_R5: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (connected && $past(connected)));

    assert_fall_has_unplug_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(connected) |-> unplug_pulse);

    assert_unplug_clears_R6: assert property (@(posedge clk) disable iff (rst)
        unplug_pulse |-> !connected);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(UNPLUG_CYC));

    assert_one_event_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_pulse, plug_pulse, unplug_pulse}));

    assert_pulse_short_R8: assert property (@(posedge clk) disable iff (rst)
        any_event |=> !any_event);

endmodule

bind hpd_pulse_classifier hpdc_checker #(
    .UNPLUG_CYC(UNPLUG_CYC),
    .CNT_W     (CNT_W)
) u_hpdc_checker (
    .clk         (clk),
    .rst         (rst),
    .connected   (connected),
    .irq_pulse   (irq_pulse),
    .plug_pulse  (plug_pulse),
    .unplug_pulse(unplug_pulse),
    .count       (run_count)
);

// File: tb/test_hpd_pulse_classifier.sv
`timescale 1ns/1ps
module test_hpd_pulse_classifier;

    localparam int G        = 8;
    localparam int U        = 40;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hpd_raw = 1'b0;
    logic connected, irq_pulse, plug_pulse, unplug_pulse;

    int total = 0;
    int fails = 0;
    int n_irq = 0, n_plug = 0, n_unplug = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hpd_pulse_classifier #(.GLITCH_CYC(G), .UNPLUG_CYC(U)) i_hpd_pulse_classifier (
        .clk(clk), .rst(rst), .hpd_raw(hpd_raw),
        .connected(connected), .irq_pulse(irq_pulse),
        .plug_pulse(plug_pulse), .unplug_pulse(unplug_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench model built from the requirements
    bit d1, d2, s_m, m_conn, e_irq, e_plug, e_unplug;
    int hi_run, lo_run;

    always @(posedge clk) begin
        if (rst) begin
            d1 = 0; d2 = 0; hi_run = 0; lo_run = 0; m_conn = 0;
            e_irq = 0; e_plug = 0; e_unplug = 0;
        end else begin
            s_m = d2; d2 = d1; d1 = hpd_raw;   // R9: two-edge delay
            e_irq = 0; e_plug = 0; e_unplug = 0;
            if (s_m) begin
                hi_run = (hi_run < U) ? hi_run + 1 : hi_run;
                if (m_conn && lo_run >= G) e_irq = 1;
                lo_run = 0;
                if (!m_conn && hi_run == G) begin m_conn = 1; e_plug = 1; end
            end else begin
                lo_run = (lo_run < U) ? lo_run + 1 : lo_run;
                hi_run = 0;
                if (m_conn && lo_run == U) begin m_conn = 0; e_unplug = 1; end
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (plug_pulse) n_plug++;
        if (irq_pulse) n_irq++;
        if (unplug_pulse) n_unplug++;
        if (!rst && !done) begin
            check(connected == m_conn, "R2 R6 R9 connected", connected, m_conn);
            check(plug_pulse == e_plug, "R2 R3 R9 plug", plug_pulse, e_plug);
            check(irq_pulse == e_irq, "R4 R5 R7 irq", irq_pulse, e_irq);
            check(unplug_pulse == e_unplug, "R6 R7 unplug", unplug_pulse, e_unplug);
        end
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            total++; fails++;
            $display("FAIL R1 watchdog: cycles=%0d expected<%0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic drive(input bit lvl, input int n);
        hpd_raw = lvl;
        repeat (n) @(negedge clk);
    endtask

    function automatic int pick_len(input int bucket);
        case (bucket)
            0: return 1 + int'($urandom_range(G - 2));
            1: return G;
            2: return G + 1 + int'($urandom_range(U - G - 2));
            3: return U - 1;
            4: return U;
            default: return U + 1 + int'($urandom_range(30));
        endcase
    endfunction

    initial begin
        int p0, i0, u0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // r1_ reset state
        check(!connected && !irq_pulse && !plug_pulse && !unplug_pulse, "R1 reset outputs",
              {connected, irq_pulse, plug_pulse, unplug_pulse}, 0);
        rst = 1'b0;
        drive(0, 5);
        check(connected == 0, "R1 idle after reset", connected, 0);

        // R3: high run one short
        drive(1, G - 1);
        drive(0, 10);
        check(n_plug == 0, "R3 short high no plug", n_plug, 0);
        check(connected == 0, "R3 stays disconnected", connected, 0);

        // R9 and R2: plug timing
        hpd_raw = 1'b1;
        repeat (G + 1) @(negedge clk);
        check(n_plug == 0, "R9 no plug before latency", n_plug, 0);
        @(negedge clk);
        check(plug_pulse == 1, "R9 plug at G+2 edges", plug_pulse, 1);
        check(connected == 1, "R2 connected with plug", connected, 1);
        @(negedge clk);
        check(plug_pulse == 0, "R8 plug one cycle", plug_pulse, 0);
        drive(1, 10);
        check(n_plug == 1, "R2 one plug", n_plug, 1);

        // R4: glitch low
        drive(0, G - 1);
        drive(1, 10);
        check(n_irq == 0 && connected == 1, "R4 glitch ignored", n_irq, 0);

        // R5: low exactly G, then U-1
        drive(0, G);
        drive(1, 10);
        check(n_irq == 1, "R5 irq at G", n_irq, 1);
        drive(0, U - 1);
        drive(1, 10);
        check(n_irq == 2, "R5 irq at U-1", n_irq, 2);
        check(connected == 1 && n_unplug == 0, "R5 stays connected", connected, 1);

        // R6: low exactly U, observed while still low
        hpd_raw = 1'b0;
        repeat (U + 3) @(negedge clk);
        check(connected == 0, "R6 cleared while low", connected, 0);
        check(n_unplug == 1, "R6 unplug once", n_unplug, 1);

        // R7: long low, then a short high
        drive(0, 200);
        drive(1, 3);
        drive(0, 10);
        check(n_irq == 2 && n_unplug == 1 && n_plug == 1, "R7 no events after long low",
              n_irq + n_unplug + n_plug, 4);

        // reconnect after unplug
        drive(1, G + 10);
        check(n_plug == 2 && connected == 1, "R2 replug", n_plug, 2);

        // random runs around both thresholds
        p0 = n_plug; i0 = n_irq; u0 = n_unplug;
        for (int k = 0; k < 300; k++) begin
            drive(0, pick_len(int'($urandom_range(5))));
            drive(1, ($urandom_range(3) == 0) ? 1 + int'($urandom_range(G - 2))
                                                : G + int'($urandom_range(20)));
        end
        drive(1, 5);
        check((n_plug - p0) + (n_irq - i0) + (n_unplug - u0) > 0, "R8 random produced events",
              (n_plug - p0) + (n_irq - i0) + (n_unplug - u0), 1);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule